// File: doc/BRIEF.md
# Phase Signature Table

This block turns the calling-context signature that closes each monitoring interval into a short phase number. A signature is up to `SLOTS` address pairs (one pair per stack level, slot 0 the outermost level) plus a length that says how many of the pairs are meaningful. The table remembers up to `ENTRIES` past signatures together with the phase number each one was given. When a new signature arrives it is compared against every remembered one at the same time. If one matches exactly, its phase number is returned. If none matches, the signature is stored with a fresh number taken from a wrapping allocation counter. When the table has no free slot, the slot that has gone longest without a hit or a fill is overwritten.

A consumer such as a profiler or a next-phase predictor watches `phase_valid`. It reads `phase_id`, and uses `phase_new` to tell a phase seen before from one never seen. The result always appears a fixed two cycles after the input strobe. A new signature may be offered on every cycle.

Top module: `psig_table`

## Requirements
- R1: Each cycle with `sig_valid` high produces exactly one cycle of `phase_valid` two clock cycles later. Strobes on consecutive cycles are accepted, and a repeat of a signature on the very next cycle sees the entry its predecessor created.
- R2: When the incoming length equals a stored entry's length and every pair below that length is equal, the stored phase number is returned with `phase_new` low.
- R3: Pair slots at positions at or above `sig_len` take no part in the comparison. Their content has no effect on the result.
- R4: Signatures of different lengths never match, even when the shorter one is a prefix of the longer one.
- R5: A signature that matches nothing gets `phase_new` high and a phase number from a counter. The counter is 0 after reset, rises by one on each allocation and wraps modulo 2^`ID_W`.
- R6: A length of zero is a valid signature in its own right. A second empty signature hits the first, whatever the pair slots hold.
- R7: `phase_new` is never high unless `phase_valid` is high.
- R8: While free slots remain, an allocation evicts nothing: every stored signature still hits.
- R9: On a miss with the table full, the entry least recently hit or filled is replaced. A hit counts as a use. The evicted signature's phase number is not handed out again: it comes back only through counter wrap.
- R10: A synchronous reset empties the table and clears the counter, so a signature seen before reset is new after it and gets number 0.
- R11: In the cycles after reset, with no input strobe, `phase_valid` and `phase_new` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_valid | input | 1 | Signature present this cycle |
| sig_len | input | $clog2(SLOTS+1) | Number of meaningful pairs; values above SLOTS are treated as SLOTS |
| sig_addr | input | SLOTS*2*ADDR_W | Address pairs, slot j in bits [j*2*ADDR_W +: 2*ADDR_W] |
| phase_valid | output | 1 | Result strobe, two cycles after `sig_valid` |
| phase_id | output | ID_W | Phase number of the signature |
| phase_new | output | 1 | High when the signature was allocated rather than found |

## Verification
The hardest situation to reach is a replacement decision: the table must first be completely full, and then its recency order must be disturbed by hits before the miss. The stimulus fills all entries with distinct one-level signatures, then hits one middle entry and the oldest entry. It then offers a fresh signature, and the old entry that was not touched must be the one that disappears. A second long run allocates more than 2^`ID_W` distinct signatures, so the numbering wraps while evictions happen on every miss.

// File: rtl/psig_pkg.sv
package psig_pkg;
  // Outcome of one lookup in the resolve stage.
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_FILL  = 2'd2,
    LK_EVICT = 2'd3
  } lookup_e;
endpackage

// File: rtl/psig_capture.sv
// Input stage: clamps the length and zeroes pair slots beyond it, so that
// stored signatures can be compared as whole vectors.
module psig_capture #(
  parameter int SLOTS  = 4,
  parameter int PAIR_W = 24,
  parameter int LEN_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [LEN_W-1:0]        in_len,
  input  logic [SLOTS*PAIR_W-1:0] in_sig,
  output logic                    out_vld,
  output logic [LEN_W-1:0]        out_len,
  output logic [SLOTS*PAIR_W-1:0] out_sig
);
  localparam int SIG_W = SLOTS * PAIR_W;

  logic [LEN_W-1:0] len_c;
  logic [SIG_W-1:0] sig_m;

  always_comb len_c = (in_len > LEN_W'(SLOTS)) ? LEN_W'(SLOTS) : in_len;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign sig_m[j*PAIR_W +: PAIR_W] = (LEN_W'(j) < len_c) ? in_sig[j*PAIR_W +: PAIR_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
    if (in_vld) begin
      out_len <= len_c;
      out_sig <= sig_m;
    end
  end
endmodule

// File: rtl/psig_match.sv
// Parallel exact-equality search over all stored entries.
module psig_match #(
  parameter int ENTRIES = 64,
  parameter int SIG_W   = 96,
  parameter int LEN_W   = 3,
  parameter int IDX_W   = 6
) (
  input  logic [SIG_W-1:0]   key_sig,
  input  logic [LEN_W-1:0]   key_len,
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic [SIG_W-1:0]   ent_sig [ENTRIES],
  input  logic [LEN_W-1:0]   ent_len [ENTRIES],
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent_vld[i] && (ent_len[i] == key_len) && (ent_sig[i] == key_sig);
  end

  assign hit = |hit_vec;

  // At most one entry can match, so OR-ing the indices encodes it.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/psig_lru.sv
// Recency tracking with one age counter per entry (0 = most recent).
module psig_lru #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic               free_found,
  output logic [IDX_W-1:0]   free_idx,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] age [ENTRIES];
  logic             fresh;
  logic [IDX_W-1:0] touched_age;

  assign fresh       = !ent_vld[touch_idx];
  assign touched_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= '0;
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)
          age[i] <= '0;
        else if (ent_vld[i] && (fresh || age[i] < touched_age))
          age[i] <= age[i] + 1'b1;
      end
    end
  end

  // Lowest-numbered empty slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // Oldest valid slot.
  always_comb begin
    logic [IDX_W-1:0] best_age;
    best_age   = '0;
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_vld[i] && age[i] >= best_age) begin
        best_age   = age[i];
        victim_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/psig_table.sv
module psig_table
  import psig_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 12,
  parameter int ID_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sig_valid,
  input  logic [$clog2(SLOTS+1)-1:0]    sig_len,
  input  logic [SLOTS*2*ADDR_W-1:0]     sig_addr,
  output logic                          phase_valid,
  output logic [ID_W-1:0]               phase_id,
  output logic                          phase_new
);
  localparam int PAIR_W = 2 * ADDR_W;
  localparam int SIG_W  = SLOTS * PAIR_W;
  localparam int LEN_W  = $clog2(SLOTS + 1);
  localparam int IDX_W  = $clog2(ENTRIES);

  // Stage 1: captured, masked signature.
  logic             s1_vld;
  logic [LEN_W-1:0] s1_len;
  logic [SIG_W-1:0] s1_sig;

  // Table storage.
  logic [ENTRIES-1:0] tbl_vld;
  logic [SIG_W-1:0]   tbl_sig [ENTRIES];
  logic [LEN_W-1:0]   tbl_len [ENTRIES];
  logic [ID_W-1:0]    tbl_id  [ENTRIES];
  logic [ID_W-1:0]    id_ctr;

  // Stage 2 decision.
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] wr_idx;
  lookup_e          kind;
  logic             alloc;

  psig_capture #(.SLOTS(SLOTS), .PAIR_W(PAIR_W), .LEN_W(LEN_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (sig_valid),
    .in_len  (sig_len),
    .in_sig  (sig_addr),
    .out_vld (s1_vld),
    .out_len (s1_len),
    .out_sig (s1_sig)
  );

  psig_match #(.ENTRIES(ENTRIES), .SIG_W(SIG_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_match (
    .key_sig (s1_sig),
    .key_len (s1_len),
    .ent_vld (tbl_vld),
    .ent_sig (tbl_sig),
    .ent_len (tbl_len),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  psig_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .ent_vld    (tbl_vld),
    .touch      (s1_vld),
    .touch_idx  (wr_idx),
    .free_found (free_found),
    .free_idx   (free_idx),
    .victim_idx (victim_idx)
  );

  always_comb begin
    if (!s1_vld)         kind = LK_NONE;
    else if (hit)        kind = LK_HIT;
    else if (free_found) kind = LK_FILL;
    else                 kind = LK_EVICT;
  end

  assign alloc  = (kind == LK_FILL) || (kind == LK_EVICT);
  assign wr_idx = hit ? hit_idx : (free_found ? free_idx : victim_idx);

  // Entry payload: written only, no reset (RAM-style).
  always_ff @(posedge clk) begin
    if (alloc) begin
      tbl_sig[wr_idx] <= s1_sig;
      tbl_len[wr_idx] <= s1_len;
      tbl_id[wr_idx]  <= id_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_vld     <= '0;
      id_ctr      <= '0;
      phase_valid <= 1'b0;
      phase_new   <= 1'b0;
      phase_id    <= '0;
    end else begin
      phase_valid <= s1_vld;
      phase_new   <= alloc;
      if (alloc) begin
        tbl_vld[wr_idx] <= 1'b1;
        id_ctr          <= id_ctr + 1'b1;
      end
      if (kind == LK_HIT)  phase_id <= tbl_id[hit_idx];
      else if (alloc)      phase_id <= id_ctr;
    end
  end
endmodule

// File: rtl/psig_table_chk.sv
module psig_table_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            sig_valid,
  input logic            phase_valid,
  input logic            phase_new,
  input logic [ID_W-1:0] phase_id
);
  logic            dly1, dly2;
  logic [1:0]      cyc;
  logic [ID_W-1:0] alloc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly1      <= 1'b0;
      dly2      <= 1'b0;
      cyc       <= '0;
      alloc_cnt <= '0;
    end else begin
      dly1      <= sig_valid;
      dly2      <= dly1;
      if (cyc != 2'd3) cyc <= cyc + 1'b1;
      if (phase_new) alloc_cnt <= alloc_cnt + 1'b1;
    end
  end

  // R1: one result strobe per input strobe, two cycles later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    phase_valid == dly2);

  // R7: new flag only with a valid result
  a_r7_new_has_valid: assert property (@(posedge clk) disable iff (rst)
    phase_new |-> phase_valid);

  // R5: allocations hand out consecutive numbers from zero
  a_r5_fresh_id_sequence: assert property (@(posedge clk) disable iff (rst)
    phase_new |-> (phase_id == alloc_cnt));

  // R11: quiet first cycle after reset
  a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd1) |-> (!phase_valid && !phase_new));
endmodule

bind psig_table psig_table_chk #(.ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sig_valid   (sig_valid),
  .phase_valid (phase_valid),
  .phase_new   (phase_new),
  .phase_id    (phase_id)
);

// File: tb/psig_table_tb.sv
`timescale 1ns/1ps
module psig_table_tb;
  localparam int ENTRIES = 64;
  localparam int SLOTS   = 4;
  localparam int ADDR_W  = 12;
  localparam int ID_W    = 8;
  localparam int LEN_W   = $clog2(SLOTS + 1);
  localparam int SIG_W   = SLOTS * 2 * ADDR_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sig_valid = 1'b0;
  logic [LEN_W-1:0] sig_len = '0;
  logic [SIG_W-1:0] sig_addr = '0;
  logic             phase_valid;
  logic [ID_W-1:0]  phase_id;
  logic             phase_new;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  psig_table #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst(rst), .sig_valid(sig_valid), .sig_len(sig_len), .sig_addr(sig_addr),
    .phase_valid(phase_valid), .phase_id(phase_id), .phase_new(phase_new)
  );

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [SIG_W-1:0] sig;
    logic [ID_W-1:0]  id;
    logic             nw;
    logic [3:0]       req;
  } vec_t;

  // Slot 0 in the low 24 bits. Run from a fresh reset.
  localparam vec_t VECS [8] = '{
    '{3'd2, 96'h000000_000000_300400_100200, 8'd0, 1'b1, 4'd5}, // R5 first allocation
    '{3'd2, 96'h000000_abcdef_300400_100200, 8'd0, 1'b0, 4'd3}, // R3 slot above len ignored
    '{3'd3, 96'h000000_500600_300400_100200, 8'd1, 1'b1, 4'd4}, // R4 longer, same prefix
    '{3'd0, 96'h000000_000000_000000_000000, 8'd2, 1'b1, 4'd6}, // R6 empty signature
    '{3'd0, 96'h000000_000000_000000_111111, 8'd2, 1'b0, 4'd6}, // R6 empty hits empty
    '{3'd2, 96'h000000_000000_300400_100200, 8'd0, 1'b0, 4'd2}, // R2 exact hit
    '{3'd1, 96'h000000_000000_000000_100200, 8'd3, 1'b1, 4'd4}, // R4 shorter prefix
    '{3'd3, 96'h000000_500600_300400_100200, 8'd1, 1'b0, 4'd2}  // R2 hit on 3 levels
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sig_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_one(input logic [LEN_W-1:0] len, input logic [SIG_W-1:0] sig,
                         input logic [ID_W-1:0] eid, input logic enew, input string tag);
    @(negedge clk);
    sig_valid = 1'b1;
    sig_len   = len;
    sig_addr  = sig;
    @(negedge clk);
    sig_valid = 1'b0;
    chk({tag, " (R1 no early strobe)"}, 32'(phase_valid), 32'd0);
    @(negedge clk);
    chk({tag, " (R1 strobe)"}, 32'(phase_valid), 32'd1);
    chk({tag, " new flag"}, 32'(phase_new), 32'(enew));
    chk({tag, " phase id"}, 32'(phase_id), 32'(eid));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11: outputs quiet after reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 valid low after reset", 32'(phase_valid), 32'd0);
      chk("R11 new low after reset", 32'(phase_new), 32'd0);
    end

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      run_one(VECS[v].len, VECS[v].sig, VECS[v].id, VECS[v].nw,
              $sformatf("R%0d vector %0d", VECS[v].req, v));
    end

    // R1: back-to-back strobes, repeat sees predecessor's entry
    @(negedge clk);
    sig_valid = 1'b1; sig_len = 3'd1; sig_addr = 96'h0000_0000_0000_0000_00ab_cdef;
    @(negedge clk);
    @(negedge clk);
    sig_valid = 1'b0;
    chk("R1 b2b first strobe", 32'(phase_valid), 32'd1);
    chk("R1 b2b first new", 32'(phase_new), 32'd1);
    chk("R1 b2b first id", 32'(phase_id), 32'd4);
    @(negedge clk);
    chk("R1 b2b second strobe", 32'(phase_valid), 32'd1);
    chk("R1 b2b second hit", 32'(phase_new), 32'd0);
    chk("R1 b2b second id", 32'(phase_id), 32'd4);
    @(negedge clk);
    chk("R1 single strobe per input", 32'(phase_valid), 32'd0);

    // R10: reset forgets table and counter
    do_reset();
    run_one(3'd2, 96'h000000_000000_300400_100200, 8'd0, 1'b1, "R10 known sig new after reset");

    // R8: fill the remaining slots, nothing evicted
    for (int i = 1; i < ENTRIES; i++)
      run_one(3'd1, 96'(32'h1000 + i), ID_W'(i), 1'b1, "R8 fill");
    run_one(3'd1, 96'(32'h1020), 8'd32, 1'b0, "R8 middle entry kept");
    run_one(3'd2, 96'h000000_000000_300400_100200, 8'd0, 1'b0, "R8 first entry kept");

    // R9: full table, LRU now holds 0x1001
    run_one(3'd1, 96'(32'h7777), 8'd64, 1'b1, "R9 miss when full");
    run_one(3'd1, 96'(32'h1001), 8'd65, 1'b1, "R9 LRU was evicted, fresh id");
    run_one(3'd1, 96'(32'h1003), 8'd3, 1'b0, "R9 younger entry kept");
    run_one(3'd2, 96'h000000_000000_300400_100200, 8'd0, 1'b0, "R9 touched entry kept");
    run_one(3'd1, 96'(32'h1002), 8'd66, 1'b1, "R9 second eviction");

    // R5: counter wraps modulo 2^ID_W
    do_reset();
    for (int k = 0; k <= (1 << ID_W); k++)
      run_one(3'd1, 96'(32'h2000 + k), ID_W'(k), 1'b1, "R5 wrap sequence");
    run_one(3'd1, 96'(32'h2000 + (1 << ID_W)), 8'd0, 1'b0, "R5 wrapped id hit");
    run_one(3'd1, 96'(32'h2000), 8'd1, 1'b1, "R5 evicted id not reused before wrap");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule